// File: doc/BRIEF.md
# Multi-Block Erase Scheduler

This controller gathers a list of storage blocks to be erased and then works through them one at a time with a modelled erase. Each erase takes a fixed number of clock cycles. Block indices arrive as a valid/ready stream. Every accepted index opens a selection window, or restarts it if it is already open. The window is measured in ticks of an external microsecond time base. When the window runs out with no new index, the list is frozen and erasing begins. Blocks whose protect bit is set at that moment are dropped without any error. If every block on the list is protected, the controller still reports a started run. That run ends on its own after a short tick count and changes nothing.

A run can be suspended and resumed any number of times. A suspend during the selection window freezes the list at once, and the following resume starts erasing immediately. A suspend during erasing parks the current block with its progress kept, and the matching resume carries on from that point. An abort empties everything within one cycle and clears the sticky error flag. A fault input models a failing erase. Raising it in any cycle of a block's erase makes that block fail, and the error flag stays set until an abort.

Back-pressure: an index is taken only on a cycle where `add_valid` and `add_ready` are both high. `add_ready` is low whenever the list is closed, the error flag is set, or `suspend` or `abort` is high in that same cycle. A producer holds its index until `add_ready` lets it through.

Top module: `multi_erase_sched`

## Requirements
- R1: After reset, busy, timer_started, suspended, done and err are 0, erasing is all zeros and add_ready is 1.
- R2: An accepted index i sets bit i of erasing in the next cycle. busy is 1 and timer_started is 0 while the selection window is open.
- R3: The window closes on the WIN_TICKS-th tick that arrives after the most recent accepted index. A tick in the same cycle as an accepted index does not count, and each accepted index restarts the count.
- R4: Once erasing has started (timer_started is 1), add_ready is 0 and further indices leave erasing unchanged.
- R5: At the close of the window, blocks with their protect bit set are dropped. The rest are erased in ascending index order, each for ERASE_CYC cycles of progress, and each block's bit clears from erasing when it finishes. done pulses for one cycle as the last block finishes.
- R6: If every listed block is protected, timer_started and busy are 1 with erasing all zeros for NULL_TICKS ticks. After that, done pulses and err stays 0.
- R7: A suspend while erasing gives suspended 1, busy 0 and timer_started 1 in the next cycle, and erasing stays frozen. The suspend cycle brings no progress. After a resume the same block continues with its remaining cycles, and this can repeat.
- R8: A suspend while the window is open gives suspended 1 with the list frozen and no indices accepted. The next resume sets timer_started in the following cycle without waiting for any tick.
- R9: A fault in any progress cycle of a block's erase sets err once that block ends. The run still completes the remaining blocks, and err stays 1 with add_ready 0 until an abort.
- R10: An abort in any state returns all outputs to their reset values in the next cycle, including err, and produces no done pulse.
- R11: The order of precedence is abort, then suspend, then resume or an accepted index, then tick. An index offered in the same cycle as a suspend is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| add_valid | input | 1 | Block index offered |
| add_idx | input | IDX_W | Index of the block to add |
| add_ready | output | 1 | Index can be taken this cycle |
| suspend | input | 1 | Suspend request pulse |
| resume | input | 1 | Resume request pulse |
| abort | input | 1 | Abort run, clear error |
| tick | input | 1 | One-microsecond time base strobe |
| fault | input | 1 | Injected erase failure for the current block |
| protect | input | NBLK | Per-block protection mask |
| busy | output | 1 | Window open, erasing, or empty run in progress |
| timer_started | output | 1 | Erasing has begun (also while suspended after start) |
| suspended | output | 1 | Run is parked by a suspend |
| erasing | output | NBLK | Blocks on the list and not yet finished |
| done | output | 1 | One-cycle pulse at normal run completion |
| err | output | 1 | Sticky erase failure flag |

## Verification
The assertions take for granted that the inputs are synchronous and change only between clock edges. They also assume an abort is honoured in the cycle it is sampled. They place no limits on how suspend, resume and indices combine. The stimulus keeps resume pulses to states where they matter and lets the tick input run free or drives it by hand. It combines index and suspend in one cycle in a single case only, to test precedence. The bench model follows the documented precedence order, so stimulus that mixes controls still has a defined expected response.

// File: rtl/esch_pkg.sv
package esch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN,
    ST_WIN_HELD,
    ST_RUN,
    ST_RUN_HELD,
    ST_VOID
  } esch_state_e;
endpackage

// File: rtl/esch_counter.sv
module esch_counter #(
  parameter int LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  assign expire = inc && (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (inc) cnt_q <= expire ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/esch_lowest.sv
module esch_lowest #(
  parameter int N = 16
) (
  input  logic [N-1:0] vec,
  output logic [N-1:0] oh
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign oh[i]       = vec[i] & ~seen[i];
    assign seen[i + 1] = seen[i] | vec[i];
  end
endmodule

// File: rtl/multi_erase_sched.sv
module multi_erase_sched
  import esch_pkg::*;
#(
  parameter int NBLK       = 16,
  parameter int WIN_TICKS  = 50,
  parameter int NULL_TICKS = 100,
  parameter int ERASE_CYC  = 1000,
  localparam int IDX_W     = (NBLK > 1) ? $clog2(NBLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_valid,
  input  logic [IDX_W-1:0] add_idx,
  output logic             add_ready,
  input  logic             suspend,
  input  logic             resume,
  input  logic             abort,
  input  logic             tick,
  input  logic             fault,
  input  logic [NBLK-1:0]  protect,
  output logic             busy,
  output logic             timer_started,
  output logic             suspended,
  output logic [NBLK-1:0]  erasing,
  output logic             done,
  output logic             err
);
  esch_state_e st_q, st_n;
  logic [NBLK-1:0] sel_q, pend_q, add_oh, low_oh, live;
  logic add_acc, start_evt, live_none;
  logic win_inc, win_clr, win_exp;
  logic void_inc, void_clr, void_exp;
  logic cell_inc, cell_clr, blk_end, last_blk;
  logic cur_fail_q, err_q, done_q;

  // index decode; out-of-range indices select nothing
  for (genvar i = 0; i < NBLK; i++) begin : g_dec
    assign add_oh[i] = (add_idx == IDX_W'(i));
  end

  assign add_ready = ((st_q == ST_IDLE) || (st_q == ST_WIN)) && !err_q && !suspend && !abort;
  assign add_acc   = add_valid && add_ready;
  assign live      = sel_q & ~protect;
  assign live_none = (live == '0);

  // selection window
  assign win_inc = (st_q == ST_WIN) && tick && !suspend && !abort && !add_acc;
  assign win_clr = add_acc || (st_q == ST_IDLE) || abort;
  esch_counter #(.LIMIT(WIN_TICKS)) i_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .inc(win_inc), .expire(win_exp)
  );

  assign start_evt = !abort && (win_exp || ((st_q == ST_WIN_HELD) && resume));

  // empty run when every listed block is protected
  assign void_inc = (st_q == ST_VOID) && tick && !abort;
  assign void_clr = start_evt || abort;
  esch_counter #(.LIMIT(NULL_TICKS)) i_void (
    .clk(clk), .rst_n(rst_n), .clr(void_clr), .inc(void_inc), .expire(void_exp)
  );

  // per-block erase progress
  assign cell_inc = (st_q == ST_RUN) && !suspend && !abort;
  assign cell_clr = start_evt || abort;
  esch_counter #(.LIMIT(ERASE_CYC)) i_cell (
    .clk(clk), .rst_n(rst_n), .clr(cell_clr), .inc(cell_inc), .expire(blk_end)
  );

  esch_lowest #(.N(NBLK)) i_low (.vec(pend_q), .oh(low_oh));
  assign last_blk = ((pend_q & ~low_oh) == '0);

  always_comb begin
    st_n = st_q;
    if (abort) st_n = ST_IDLE;
    else begin
      unique case (st_q)
        ST_IDLE:     if (add_acc) st_n = ST_WIN;
        ST_WIN: begin
          if (suspend) st_n = ST_WIN_HELD;
          else if (start_evt) st_n = live_none ? ST_VOID : ST_RUN;
        end
        ST_WIN_HELD: if (start_evt) st_n = live_none ? ST_VOID : ST_RUN;
        ST_RUN: begin
          if (suspend) st_n = ST_RUN_HELD;
          else if (blk_end && last_blk) st_n = ST_IDLE;
        end
        ST_RUN_HELD: if (resume) st_n = ST_RUN;
        ST_VOID:     if (void_exp) st_n = ST_IDLE;
        default:     st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      sel_q      <= '0;
      pend_q     <= '0;
      cur_fail_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= !abort && ((blk_end && last_blk) || void_exp);

      if (st_n == ST_IDLE) sel_q <= '0;
      else if (add_acc) sel_q <= sel_q | add_oh;

      if (abort) pend_q <= '0;
      else if (start_evt) pend_q <= live;
      else if (blk_end) pend_q <= pend_q & ~low_oh;

      if (abort || start_evt || blk_end) cur_fail_q <= 1'b0;
      else if (cell_inc && fault) cur_fail_q <= 1'b1;

      if (abort) err_q <= 1'b0;
      else if (blk_end && (cur_fail_q || fault)) err_q <= 1'b1;
    end
  end

  assign busy          = (st_q == ST_WIN) || (st_q == ST_RUN) || (st_q == ST_VOID);
  assign timer_started = (st_q == ST_RUN) || (st_q == ST_RUN_HELD) || (st_q == ST_VOID);
  assign suspended     = (st_q == ST_WIN_HELD) || (st_q == ST_RUN_HELD);
  assign erasing       = ((st_q == ST_WIN) || (st_q == ST_WIN_HELD)) ? sel_q :
                         ((st_q == ST_RUN) || (st_q == ST_RUN_HELD)) ? pend_q : '0;
  assign done          = done_q;
  assign err           = err_q;
endmodule

// File: rtl/esch_sched_checker.sv
module esch_sched_checker #(
  parameter int NBLK = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            add_ready,
  input logic            suspend,
  input logic            abort,
  input logic            busy,
  input logic            timer_started,
  input logic            suspended,
  input logic [NBLK-1:0] erasing,
  input logic            done,
  input logic            err
);
  AST_RDY_ONLY_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    add_ready |-> (!timer_started && !suspended)); // R4

  AST_LIST_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
    (timer_started && !abort) |=> ((erasing & ~$past(erasing)) == '0)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R5

  AST_DONE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !suspended && (erasing == '0))); // R5

  AST_PARKED_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !busy); // R7

  AST_PARK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(suspended) |-> $past(suspend)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !abort) |=> err); // R9

  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !suspended && !err && !done && (erasing == '0))); // R10
endmodule

bind multi_erase_sched esch_sched_checker #(.NBLK(NBLK)) i_chk (
  .clk(clk), .rst_n(rst_n), .add_ready(add_ready), .suspend(suspend),
  .abort(abort), .busy(busy), .timer_started(timer_started),
  .suspended(suspended), .erasing(erasing), .done(done), .err(err)
);

// File: tb/test_multi_erase_sched.sv
module test_multi_erase_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;
  localparam int WIN = 4;
  localparam int NULLT = 3;
  localparam int ECYC = 5;

  logic clk = 0, rst_n = 0;
  logic add_valid = 0, suspend = 0, resume = 0, abort = 0, tick = 0, fault = 0;
  logic [2:0] add_idx = 0;
  logic [NB-1:0] protect = 0;
  logic add_ready, busy, timer_started, suspended, done, err;
  logic [NB-1:0] erasing;

  int tests = 0, fails = 0, cycles = 0, run_cnt = 0;
  bit tick_auto = 0, done_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  multi_erase_sched #(.NBLK(NB), .WIN_TICKS(WIN), .NULL_TICKS(NULLT), .ERASE_CYC(ECYC))
    i_multi_erase_sched (.*);

  // behavioural reference: 0 idle,1 window,2 window parked,3 erasing,4 erase parked,5 empty run
  int m_st = 0, m_wc = 0, m_ec = 0, m_nc = 0;
  bit m_err = 0, m_curf = 0, m_done = 0;
  bit [NB-1:0] m_sel = 0;
  int q[$];

  function automatic bit m_rdy();
    return (m_st == 0 || m_st == 1) && !m_err && !suspend && !abort;
  endfunction

  function automatic bit [NB-1:0] m_erasing();
    bit [NB-1:0] v = 0;
    if (m_st == 1 || m_st == 2) v = m_sel;
    else if (m_st == 3 || m_st == 4) foreach (q[k]) v[q[k]] = 1'b1;
    return v;
  endfunction

  task automatic m_start();
    q.delete();
    for (int i = 0; i < NB; i++) if (m_sel[i] && !protect[i]) q.push_back(i);
    if (q.size() == 0) begin m_st = 5; m_nc = 0; end
    else begin m_st = 3; m_ec = 0; m_curf = 0; end
  endtask

  always @(posedge clk) begin
    bit rdy;
    rdy = m_rdy();
    m_done = 0;
    if (!rst_n) begin
      m_st = 0; m_sel = 0; q.delete(); m_err = 0; m_curf = 0;
    end else if (abort) begin
      m_st = 0; m_sel = 0; q.delete(); m_err = 0; m_curf = 0;
    end else begin
      case (m_st)
        0: if (add_valid && rdy) begin m_sel = 0; m_sel[add_idx] = 1; m_wc = 0; m_st = 1; end
        1: begin
          if (suspend) m_st = 2;
          else if (add_valid && rdy) begin m_sel[add_idx] = 1; m_wc = 0; end
          else if (tick) begin m_wc++; if (m_wc == WIN) m_start(); end
        end
        2: if (resume) m_start();
        3: begin
          if (suspend) m_st = 4;
          else begin
            m_ec++;
            if (fault) m_curf = 1;
            if (m_ec == ECYC) begin
              if (m_curf) m_err = 1;
              m_curf = 0; m_ec = 0;
              void'(q.pop_front());
              if (q.size() == 0) begin m_st = 0; m_done = 1; m_sel = 0; end
            end
          end
        end
        4: if (resume) m_st = 3;
        5: if (tick) begin m_nc++; if (m_nc == NULLT) begin m_st = 0; m_done = 1; m_sel = 0; end end
        default: m_st = 0;
      endcase
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R4", "add_ready", add_ready, m_rdy());
      chk("R3", "busy", busy, (m_st == 1 || m_st == 3 || m_st == 5));
      chk("R3", "timer_started", timer_started, (m_st >= 3 && m_st != 2));
      chk("R7", "suspended", suspended, (m_st == 2 || m_st == 4));
      chk("R5", "erasing", erasing, m_erasing());
      chk("R5", "done", done, m_done);
      chk("R9", "err", err, m_err);
      if (done) done_seen = 1;
      if (busy && timer_started) run_cnt++;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog act=%0d exp=<150000", cycles);
      report();
    end
  end

  int tph = 0;
  always @(negedge clk) begin
    #1;
    if (tick_auto) begin tph = (tph + 1) % 3; tick = (tph == 0); end
  end

  task automatic cyc(int n);
    repeat (n) begin @(negedge clk); #2; end
  endtask

  task automatic add(int i);
    add_valid = 1; add_idx = 3'(i); cyc(1); add_valid = 0;
  endtask

  task automatic pulse(int which); // 0 suspend, 1 resume, 2 abort, 3 tick, 4 fault
    case (which)
      0: suspend = 1; 1: resume = 1; 2: abort = 1; 3: tick = 1; default: fault = 1;
    endcase
    cyc(1);
    suspend = 0; resume = 0; abort = 0; fault = 0;
    if (!tick_auto) tick = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && m_st != 0; i++) cyc(1);
    cyc(1);
  endtask

  task automatic wait_started();
    for (int i = 0; i < 200 && !timer_started; i++) cyc(1);
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    // R1 reset values
    chk("R1", "busy", busy, 0); chk("R1", "erasing", erasing, 0);
    chk("R1", "flags", {timer_started, suspended, done, err}, 0);
    chk("R1", "add_ready", add_ready, 1);

    // R3 window restart with hand-driven ticks, R2 list contents
    add(2);
    chk("R2", "erasing", erasing, 8'h04); chk("R2", "busy", busy, 1);
    chk("R2", "timer_started", timer_started, 0);
    repeat (WIN - 1) pulse(3);
    chk("R3", "not yet started", timer_started, 0);
    add(5);
    repeat (WIN - 1) pulse(3);
    chk("R3", "restarted window", timer_started, 0);
    pulse(3);
    chk("R3", "started on last tick", timer_started, 1);
    chk("R4", "add_ready closed", add_ready, 0);
    add(7);
    chk("R4", "list not grown", erasing, 8'h24);
    done_seen = 0; wait_idle();
    chk("R5", "done seen", done_seen, 1);

    // R5 protected block dropped
    tick_auto = 1;
    add(1); add(3); add(6); protect = 8'h08;
    wait_started(); cyc(1);
    chk("R5", "protected dropped", erasing, 8'h42);
    wait_idle(); protect = 0;

    // R6 all protected
    protect = 8'hFF; add(4); wait_started(); cyc(1);
    chk("R6", "empty list", erasing, 0); chk("R6", "busy", busy, 1);
    done_seen = 0; wait_idle();
    chk("R6", "done", done_seen, 1); chk("R6", "err", err, 0);
    protect = 0;

    // R7 suspend during erase, twice
    add(0); add(2); wait_started(); run_cnt = 1; cyc(1);
    pulse(0);
    chk("R7", "suspended", suspended, 1); chk("R7", "busy", busy, 0);
    chk("R7", "timer_started", timer_started, 1);
    cyc(6);
    chk("R7", "frozen list", erasing, 8'h05);
    pulse(1); cyc(2); pulse(0); cyc(2); pulse(1);
    wait_idle();
    chk("R7", "progress cycles", run_cnt, 2 * ECYC + 2);

    // R8 suspend during window
    add(1); pulse(0);
    chk("R8", "suspended", suspended, 1); chk("R8", "busy", busy, 0);
    add(3);
    chk("R8", "no add while parked", erasing, 8'h02);
    tick_auto = 0; tick = 0;
    pulse(1);
    chk("R8", "immediate start", timer_started, 1);
    add(4);
    chk("R4", "no add after resume", erasing, 8'h02);
    wait_idle(); tick_auto = 1;

    // R9 fault then sticky error, R10 abort clears it
    add(0); add(5); wait_started(); cyc(1); pulse(4);
    done_seen = 0; wait_idle();
    chk("R9", "err set", err, 1); chk("R9", "run completed", done_seen, 1);
    add(6);
    chk("R9", "adds refused", erasing, 0); chk("R9", "add_ready", add_ready, 0);
    pulse(2);
    chk("R10", "err cleared", err, 0);

    // R10 abort mid-erase
    add(1); add(2); wait_started(); cyc(2); pulse(2);
    chk("R10", "idle", {busy, timer_started, suspended}, 0);
    chk("R10", "erasing", erasing, 0);
    done_seen = 0; cyc(10);
    chk("R10", "no done", done_seen, 0);

    // R11 index offered together with suspend is refused
    add(1);
    add_valid = 1; add_idx = 3; suspend = 1; cyc(1); add_valid = 0; suspend = 0;
    chk("R11", "suspend wins", suspended, 1);
    chk("R11", "index refused", erasing, 8'h02);
    pulse(1); wait_idle();

    report();
  end
endmodule